// File: doc/BRIEF.md
# Parallel Printer Port with Automatic Strobe

This block is the printer-facing half of a host expansion card. The host writes a byte to the data register. The byte goes onto the parallel printer data lines, and the block then sends a timed strobe pulse to the printer by itself, so the host makes no second access to clock the byte out.

The printer's acknowledge line is resampled into the clock domain and recorded in a set/reset flag. A new data write clears the flag. Its state tells the host whether the byte most recently sent has been acknowledged. The printer's select, paper-empty and busy lines and six configuration switches are resampled as well. They are returned through two read registers with a fixed bit layout.

Top module: `lpt_autostrobe_port`

## Requirements
- R1: A write (`reg_wr` high) with `reg_addr` = 0 loads `reg_wdata` into the output latch, and `prn_data` shows the new byte directly after that clock edge.
- R2: After a data write, `prn_strobe` stays at its idle level for the cycle that follows. It becomes active on the next edge, one clock after the data changed.
- R3: The strobe stays active for exactly `STROBE_CLKS` cycles (default 2) and then returns to idle. With `STROBE_ACTIVE_HIGH` = 0 (default) the line idles high and pulses low. With 1 it idles low and pulses high.
- R4: A data write that arrives while a pulse is active ends that pulse at the same edge. A complete new pulse follows after one idle cycle. `prn_data` never changes during a cycle in which the strobe is active.
- R5: Writes to `reg_addr` 1, 2 or 3 leave `prn_data` unchanged and start no strobe.
- R6: All printer and switch inputs pass through a two-stage synchronizer. The acknowledge flag is set on the active edge of `prn_ack`, which is the falling edge when `ACK_ACTIVE_LOW` = 1 (default). A level that is held, or a transition back to the inactive level, does not set it.
- R7: Every data write clears the acknowledge flag. If a clear and an acknowledge edge fall in the same cycle, the clear wins.
- R8: A read (`reg_rd` high) of offset 0 returns, on `reg_rdata` in the following cycle:
  - bit 0: the acknowledge flag
  - bit 1: select
  - bit 2: paper-empty
  - bit 3: busy as asserted, which is the line level when `BUSY_ACTIVE_HIGH` = 1
  - bits 4 to 6: `cfg_sw[0]` to `cfg_sw[2]`
  - bit 7: 0

  `reg_rdata` is 0 in any cycle that does not follow a read.
- R9: A read of offset 3 returns `cfg_sw[3]` to `cfg_sw[5]` on bits 0 to 2, with zeros above them. Reads of offsets 1 and 2 return 0.
- R10: Reset, synchronous and active high, sets `prn_data` to 0, returns the strobe to idle, clears the acknowledge flag and sets `reg_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset of the access |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Host write data |
| prn_ack | input | 1 | Printer acknowledge (asynchronous) |
| prn_busy | input | 1 | Printer busy (asynchronous) |
| prn_pe | input | 1 | Printer paper-empty (asynchronous) |
| prn_select | input | 1 | Printer select (asynchronous) |
| cfg_sw | input | 6 | Configuration switches |
| prn_data | output | 8 | Printer data lines |
| prn_strobe | output | 1 | Printer strobe |
| reg_rdata | output | 8 | Host read data, valid the cycle after a read |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are single-cycle strobes sampled at the clock edge, and that `reg_addr` and `reg_wdata` are valid whenever a strobe is high. The bench drives every access at the falling edge, holds each strobe for exactly one cycle, and never raises read and write together. The printer and switch inputs are changed only between accesses, and the bench waits longer than the synchronizer delay before reading status back. No acknowledge edge is timed to land in the same cycle as a write.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int RD_W = 8;
  localparam int SW_N = 6;

  localparam logic [1:0] OFS_DATA  = 2'd0;
  localparam logic [1:0] OFS_SW_HI = 2'd3;

  // Status word layout, low bit last: ack flag in bit 0 up to sw_lo in bits 6:4
  typedef struct packed {
    logic [2:0] sw_lo;
    logic       busy;
    logic       pe;
    logic       sel;
    logic       ack;
  } stat_t;

  function automatic logic [RD_W-1:0] pack_status(input stat_t s);
    return {1'b0, s};
  endfunction

  function automatic logic [RD_W-1:0] pack_sw_hi(input logic [2:0] s);
    return {{(RD_W-3){1'b0}}, s};
  endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpt_strobe_gen.sv
module lpt_strobe_gen #(
  parameter int DATA_W             = 8,
  parameter int STROBE_CLKS        = 2,
  parameter bit STROBE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe,
  output logic              pulse_on
);

  localparam int   CNT_W = (STROBE_CLKS < 2) ? 1 : $clog2(STROBE_CLKS);
  localparam logic IDLE  = STROBE_ACTIVE_HIGH ? 1'b0 : 1'b1;

  logic              pend_q;
  logic              act_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      left_q   <= '0;
      strobe_q <= IDLE;
    end else if (load) begin
      data_q   <= load_data;
      pend_q   <= 1'b1;
      act_q    <= 1'b0;
      left_q   <= '0;
      strobe_q <= IDLE;
    end else if (pend_q) begin
      pend_q   <= 1'b0;
      act_q    <= 1'b1;
      left_q   <= CNT_W'(STROBE_CLKS - 1);
      strobe_q <= ~IDLE;
    end else if (act_q) begin
      if (left_q == '0) begin
        act_q    <= 1'b0;
        strobe_q <= IDLE;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign prn_data   = data_q;
  assign prn_strobe = strobe_q;
  assign pulse_on   = act_q;

endmodule

// File: rtl/lpt_ack_latch.sv
module lpt_ack_latch #(
  parameter bit ACK_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_s,
  input  logic clr,
  output logic flag
);

  localparam logic ACK_IDLE = ACK_ACTIVE_LOW ? 1'b1 : 1'b0;

  logic prev_q;
  logic flag_q;
  logic hit;

  always_comb begin
    if (ACK_ACTIVE_LOW) hit = prev_q & ~ack_s;
    else                hit = ~prev_q & ack_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= ACK_IDLE;
      flag_q <= 1'b0;
    end else begin
      prev_q <= ack_s;
      if (clr)      flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/lpt_status_mux.sv
module lpt_status_mux
  import lpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd,
  input  logic [1:0]      addr,
  input  stat_t           stat,
  input  logic [2:0]      sw_hi,
  output logic [RD_W-1:0] rdata
);

  logic [RD_W-1:0] sel_word;
  logic [RD_W-1:0] rdata_q;

  always_comb begin
    unique case (addr)
      OFS_DATA:  sel_word = pack_status(stat);
      OFS_SW_HI: sel_word = pack_sw_hi(sw_hi);
      default:   sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel_word;
    else         rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lpt_autostrobe_port.sv
module lpt_autostrobe_port
  import lpt_pkg::*;
#(
  parameter int DATA_W             = 8,
  parameter int STROBE_CLKS        = 2,
  parameter bit STROBE_ACTIVE_HIGH = 1'b0,
  parameter bit ACK_ACTIVE_LOW     = 1'b1,
  parameter bit BUSY_ACTIVE_HIGH   = 1'b1,
  parameter int SYNC_STAGES        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              prn_ack,
  input  logic              prn_busy,
  input  logic              prn_pe,
  input  logic              prn_select,
  input  logic [SW_N-1:0]   cfg_sw,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe,
  output logic [RD_W-1:0]   reg_rdata
);

  localparam int         IN_W    = 4 + SW_N;
  localparam logic       ACK_IDL = ACK_ACTIVE_LOW ? 1'b1 : 1'b0;
  localparam logic [IN_W-1:0] IN_RST = {{(IN_W-1){1'b0}}, ACK_IDL};

  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] syn_in;
  logic            ack_s, busy_s, pe_s, sel_s;
  logic [SW_N-1:0] sw_s;
  logic            data_wr;
  logic            ack_seen;
  logic            pulse_on;
  stat_t           stat;

  assign raw_in = {cfg_sw, prn_select, prn_pe, prn_busy, prn_ack};

  lpt_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign ack_s  = syn_in[0];
  assign busy_s = syn_in[1];
  assign pe_s   = syn_in[2];
  assign sel_s  = syn_in[3];
  assign sw_s   = syn_in[IN_W-1:4];

  assign data_wr = reg_wr && (reg_addr == OFS_DATA);

  lpt_strobe_gen #(
    .DATA_W             (DATA_W),
    .STROBE_CLKS        (STROBE_CLKS),
    .STROBE_ACTIVE_HIGH (STROBE_ACTIVE_HIGH)
  ) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .load       (data_wr),
    .load_data  (reg_wdata),
    .prn_data   (prn_data),
    .prn_strobe (prn_strobe),
    .pulse_on   (pulse_on)
  );

  lpt_ack_latch #(
    .ACK_ACTIVE_LOW (ACK_ACTIVE_LOW)
  ) u_ack (
    .clk   (clk),
    .rst   (rst),
    .ack_s (ack_s),
    .clr   (data_wr),
    .flag  (ack_seen)
  );

  always_comb begin
    stat.ack   = ack_seen;
    stat.sel   = sel_s;
    stat.pe    = pe_s;
    stat.busy  = BUSY_ACTIVE_HIGH ? busy_s : ~busy_s;
    stat.sw_lo = sw_s[2:0];
  end

  lpt_status_mux u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .stat  (stat),
    .sw_hi (sw_s[5:3]),
    .rdata (reg_rdata)
  );

endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk #(
  parameter int DATA_W             = 8,
  parameter int STROBE_CLKS        = 2,
  parameter bit STROBE_ACTIVE_HIGH = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] prn_data,
  input logic              prn_strobe,
  input logic [7:0]        reg_rdata,
  input logic              ack_seen
);

  localparam logic ON_LVL = STROBE_ACTIVE_HIGH ? 1'b1 : 1'b0;

  logic wr0;
  logic str_on;
  int   run_q;

  assign wr0    = reg_wr && (reg_addr == 2'd0);
  assign str_on = (prn_strobe == ON_LVL);

  always_ff @(posedge clk) begin
    if (rst)         run_q <= 0;
    else if (str_on) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  a_r1_data_loaded: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> prn_data == $past(reg_wdata));

  a_r2_idle_after_write: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> !str_on);

  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    wr0 ##1 !wr0 |=> str_on);

  a_r3_not_too_long: assert property (@(posedge clk) disable iff (rst)
    str_on |-> run_q < STROBE_CLKS);

  a_r3_full_width: assert property (@(posedge clk) disable iff (rst)
    $fell(str_on) && !$past(wr0) |-> run_q == STROBE_CLKS);

  a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
    str_on |-> $stable(prn_data));

  a_r5_other_write_keeps: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr != 2'd0 |=> $stable(prn_data));

  a_r7_write_clears_ack: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> !ack_seen);

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd && (reg_addr == 2'd1 || reg_addr == 2'd2) |=> reg_rdata == 8'd0);

  a_r8_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> reg_rdata == 8'd0);

endmodule

bind lpt_autostrobe_port lpt_port_chk #(
  .DATA_W             (DATA_W),
  .STROBE_CLKS        (STROBE_CLKS),
  .STROBE_ACTIVE_HIGH (STROBE_ACTIVE_HIGH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_wdata  (reg_wdata),
  .prn_data   (prn_data),
  .prn_strobe (prn_strobe),
  .reg_rdata  (reg_rdata),
  .ack_seen   (ack_seen)
);

// File: tb/tb_lpt_autostrobe_port.sv
module tb_lpt_autostrobe_port;

  localparam int SC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       prn_ack = 1'b1;
  logic       prn_busy = 1'b0;
  logic       prn_pe = 1'b0;
  logic       prn_select = 1'b0;
  logic [5:0] cfg_sw = '0;
  logic [7:0] prn_data;
  logic       prn_strobe;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lpt_autostrobe_port dut (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .prn_ack    (prn_ack),
    .prn_busy   (prn_busy),
    .prn_pe     (prn_pe),
    .prn_select (prn_select),
    .cfg_sw     (cfg_sw),
    .prn_data   (prn_data),
    .prn_strobe (prn_strobe),
    .reg_rdata  (reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] last;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(prn_data == 8'h00, "R10 data", prn_data, 8'h00);
    chk(prn_strobe == 1'b1, "R10 strobe", prn_strobe, 1);
    chk(reg_rdata == 8'h00, "R10 rdata", reg_rdata, 0);
    do_read(2'd0, v);
    chk(v[0] == 1'b0, "R10 ack flag", v[0], 0);

    // R1 R2 R3 every byte value
    for (int b = 0; b < 256; b++) begin
      do_write(2'd0, 8'(b));
      chk(prn_data == 8'(b), "R1 latch", prn_data, b);
      chk(prn_strobe == 1'b1, "R2 idle after write", prn_strobe, 1);
      for (int k = 0; k < SC; k++) begin
        @(negedge clk);
        chk(prn_strobe == 1'b0, "R3 active", prn_strobe, 0);
        chk(prn_data == 8'(b), "R4 data held", prn_data, b);
      end
      @(negedge clk);
      chk(prn_strobe == 1'b1, "R3 end", prn_strobe, 1);
    end
    last = 8'hFF;

    // R5 writes to other offsets
    for (int a = 1; a < 4; a++) begin
      do_write(2'(a), 8'h5A);
      chk(prn_data == last, "R5 data kept", prn_data, last);
      for (int k = 0; k < SC + 2; k++) begin
        chk(prn_strobe == 1'b1, "R5 no strobe", prn_strobe, 1);
        @(negedge clk);
      end
    end

    // R4 write while pulse active
    do_write(2'd0, 8'h11);
    @(negedge clk);
    chk(prn_strobe == 1'b0, "R4 first pulse", prn_strobe, 0);
    do_write(2'd0, 8'h22);
    chk(prn_data == 8'h22, "R4 new data", prn_data, 8'h22);
    chk(prn_strobe == 1'b1, "R4 pulse cut", prn_strobe, 1);
    for (int k = 0; k < SC; k++) begin
      @(negedge clk);
      chk(prn_strobe == 1'b0, "R4 second pulse", prn_strobe, 0);
    end
    @(negedge clk);
    chk(prn_strobe == 1'b1, "R4 second end", prn_strobe, 1);

    // R8 R9 status and switch sweep, ack flag cleared by last write
    for (int c = 0; c < 512; c++) begin
      logic [8:0] cv;
      logic [7:0] e0, e3;
      cv = 9'(c);
      prn_select = cv[0]; prn_pe = cv[1]; prn_busy = cv[2]; cfg_sw = cv[8:3];
      wait_cyc(3);
      e0 = {1'b0, cv[5:3], cv[2], cv[1], cv[0], 1'b0};
      e3 = {5'b0, cv[8:6]};
      do_read(2'd0, v);
      chk(v == e0, "R8 status", v, e0);
      do_read(2'd3, v);
      chk(v == e3, "R9 switches", v, e3);
    end
    do_read(2'd1, v);
    chk(v == 8'h00, "R9 offset1", v, 0);
    do_read(2'd2, v);
    chk(v == 8'h00, "R9 offset2", v, 0);
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R8 no read", reg_rdata, 0);

    // R6 acknowledge edge sets flag
    prn_select = 0; prn_pe = 0; prn_busy = 0; cfg_sw = 0;
    prn_ack = 1'b0;
    wait_cyc(2);
    prn_ack = 1'b1;
    wait_cyc(4);
    do_read(2'd0, v);
    chk(v[0] == 1'b1, "R6 ack set", v[0], 1);
    // R7 write clears
    do_write(2'd0, 8'h33);
    do_read(2'd0, v);
    chk(v[0] == 1'b0, "R7 cleared", v[0], 0);
    // R6 held low level and rising edge do not set
    prn_ack = 1'b0;
    wait_cyc(5);
    do_write(2'd0, 8'h44);
    wait_cyc(5);
    do_read(2'd0, v);
    chk(v[0] == 1'b0, "R6 level ignored", v[0], 0);
    prn_ack = 1'b1;
    wait_cyc(5);
    do_read(2'd0, v);
    chk(v[0] == 1'b0, "R6 rising ignored", v[0], 0);

    // R10 reset mid-run
    prn_ack = 1'b0;
    wait_cyc(5);
    prn_ack = 1'b1;
    do_write(2'd0, 8'hC3);
    prn_ack = 1'b0;
    wait_cyc(5);
    @(negedge clk); rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    chk(prn_data == 8'h00, "R10 data cleared", prn_data, 0);
    chk(prn_strobe == 1'b1, "R10 strobe idle", prn_strobe, 1);
    do_read(2'd0, v);
    chk(v[0] == 1'b0, "R10 flag cleared", v[0], 0);
    prn_ack = 1'b1;
    wait_cyc(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule